// File: doc/BRIEF.md
# Fan PWM Generator

The block drives up to three fan PWM outputs. Every output is a pulse-width modulated waveform with a programmable duty. A shared mode register holds the output polarity, a minimum-duty floor, one forced on/off bit for each fan and a 3-bit clock select. The clock select picks a base tick from the fast reference clock using one of eight divide ratios.

Each fan works in one of two modes. In smart mode its duty comes either from its own duty register or from an external controller input. In forced mode the output is held fully active or fully inactive. A build-time parameter sets the duty resolution to 7 or 8 bits. A second optional parameter gives fan 2 a clock select of its own.

Software programs the block through a single-cycle write port. A new duty is applied only when a PWM period starts, so a period is never cut short.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset, all registers are zero. Every output is then 1, which is the inactive level of active-low polarity with the fan forced off.
- R2: The clock select is held in bits 6:4 of the mode register (address 0). Codes 0 to 7 divide the reference clock by 1, 2, 4, 6, 8, 16, 32 and SLOW_DIV. One duty step lasts that many reference cycles, and one period is (full scale + 1) steps.
- R3: In smart mode the output is active for exactly `duty` steps of each period. Full scale is 127 at 7-bit resolution. A duty at or above full scale gives a constant active level, and a duty of 0 gives a constant inactive level.
- R4: Bit 7 of the mode register set to 1 makes the active level high. Set to 0, it makes the active level low.
- R5: When a fan's smart bit is clear, mode register bit (fan index) forces that output. A 1 gives a constant active level and a 0 gives a constant inactive level.
- R6: Mode register bit 3 raises any effective duty below floor(full scale × 20 / 100) to that floor, and this includes a duty of 0. The floor is 25 at 7 bits and 51 at 8 bits.
- R7: A duty written in the middle of a period does not change that period. The new value takes effect at the next period start.
- R8: At address 1, bit f sets smart mode for fan f. Bit 4+f selects the external duty input `ext_duty[8f+7:8f]` in place of the duty register.
- R9: With SEP_CLK2 set, fan 2 (index 1) takes its clock select from bits 6:4 at address 2. The other fans keep the shared select.
- R10: With DUTY_BITS = 8, full scale is 255, and a duty of 255 gives a constant active level.
- R11: The duty register for fan f is at address 4+f. A write to any other unmapped address changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| ext_duty | input | 8*NUM_FANS | External duty per fan |
| pwm_out | output | NUM_FANS | PWM outputs |

## Verification
Most internal faults change the number of active cycles in a period. A bad period counter or a bad duty shadow shows within one period as a wrong active count over a window of full scale + 1 steps. A wrong prescaler divide shows at the first complete pulse as a wrong high-run length. A shadow that updates early is seen within the same period: the pulse is cut at the new duty instead of finishing at the old one. A polarity or forced-mode fault shows at the output one cycle after the register write.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

  localparam logic [3:0] ADDR_MODE   = 4'h0;
  localparam logic [3:0] ADDR_FANCTL = 4'h1;
  localparam logic [3:0] ADDR_CLK2   = 4'h2;
  localparam logic [3:0] ADDR_DUTY0  = 4'h4;

  // shared mode register layout
  typedef struct packed {
    logic       act_high;
    logic [2:0] clk_sel;
    logic       min_en;
    logic [2:0] force_on;
  } mode_t;

  // reference-clock cycles per duty step for each select code
  function automatic int unsigned step_div(input logic [2:0] sel, input int unsigned slow_div);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 16;
      3'd6:    return 32;
      default: return slow_div;
    endcase
  endfunction

endpackage

// File: rtl/fanpwm_prescale.sv
module fanpwm_prescale
  import fanpwm_pkg::*;
#(
  parameter int SLOW_DIV = 938
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  localparam int MAX_DIV = (SLOW_DIV > 32) ? SLOW_DIV : 32;
  localparam int CW      = $clog2(MAX_DIV);

  logic [CW-1:0] cnt_q, cnt_d, last_cnt;

  always_comb begin
    last_cnt = CW'(step_div(sel_i, SLOW_DIV) - 1);
    tick_o   = (cnt_q >= last_cnt);
    cnt_d    = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: any divide other than 1 never gives back-to-back ticks
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_i != 3'd0) |=> (!tick_o || sel_i == 3'd0));

endmodule

// File: rtl/fanpwm_chan.sv
module fanpwm_chan #(
  parameter int DUTY_BITS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       smart_i,
  input  logic       force_i,
  input  logic       act_high_i,
  input  logic       min_en_i,
  input  logic       ext_sel_i,
  input  logic [7:0] reg_duty_i,
  input  logic [7:0] ext_duty_i,
  output logic       pwm_o
);
  localparam int                   FULL    = (1 << DUTY_BITS) - 1;
  localparam logic [DUTY_BITS-1:0] FS      = DUTY_BITS'(FULL);
  localparam logic [7:0]           FS8     = 8'(FULL);
  localparam logic [DUTY_BITS-1:0] MIN_D   = DUTY_BITS'((FULL * 20) / 100);

  logic [DUTY_BITS-1:0] cnt_q, cnt_d, duty_q, duty_d;
  logic [DUTY_BITS-1:0] duty_sat, duty_eff;
  logic [7:0]           duty_raw;
  logic                 wrap, active, pwm_d;

  // duty source, saturation and floor
  always_comb begin
    duty_raw = ext_sel_i ? ext_duty_i : reg_duty_i;
    duty_sat = (duty_raw >= FS8) ? FS : duty_raw[DUTY_BITS-1:0];
    duty_eff = (min_en_i && duty_sat < MIN_D) ? MIN_D : duty_sat;
  end

  // period counter and duty shadow, both advanced by the tick enable
  always_comb begin
    wrap   = tick_i && (cnt_q == FS);
    cnt_d  = cnt_q;
    duty_d = duty_q;
    if (tick_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (wrap)   duty_d = duty_eff;
  end

  always_comb begin
    if (smart_i) active = (duty_q == FS) || (cnt_q < duty_q);
    else         active = force_i;
    pwm_d = act_high_i ? active : !active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pwm_o  <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
      pwm_o  <= pwm_d;
    end
  end

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q));
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && min_en_i) |=> (duty_q >= MIN_D));
  a_r5_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !smart_i |=> (pwm_o == $past(force_i ~^ act_high_i)));
  a_r3_full_on: assert property (@(posedge clk) disable iff (!rst_n)
    (smart_i && duty_q == FS) |=> (pwm_o == $past(act_high_i)));
  a_r3_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (smart_i && duty_q == '0) |=> (pwm_o == !$past(act_high_i)));

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fanpwm_pkg::*;
#(
  parameter int NUM_FANS  = 3,
  parameter int DUTY_BITS = 7,
  parameter int SLOW_DIV  = 938,
  parameter bit SEP_CLK2  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [3:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [8*NUM_FANS-1:0] ext_duty,
  output logic [NUM_FANS-1:0]   pwm_out
);
  localparam bit HAS_CLK2 = SEP_CLK2 && (NUM_FANS > 1);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mode_t                     mode_q, mode_d;
  logic [NUM_FANS-1:0]       smart_q, smart_d, xsel_q, xsel_d;
  logic [NUM_FANS-1:0][7:0]  duty_q, duty_d;
  logic                      tick_main, tick_alt;

  always_comb begin
    mode_d  = mode_q;
    smart_d = smart_q;
    xsel_d  = xsel_q;
    duty_d  = duty_q;
    if (wr_en) begin
      if (wr_addr == ADDR_MODE) mode_d = mode_t'(wr_data);
      if (wr_addr == ADDR_FANCTL) begin
        smart_d = wr_data[NUM_FANS-1:0];
        xsel_d  = wr_data[4 +: NUM_FANS];
      end
      for (int f = 0; f < NUM_FANS; f++)
        if (wr_addr == ADDR_DUTY0 + 4'(f)) duty_d[f] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q  <= '0;
      smart_q <= '0;
      xsel_q  <= '0;
      duty_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      smart_q <= smart_d;
      xsel_q  <= xsel_d;
      duty_q  <= duty_d;
    end
  end

  fanpwm_prescale #(.SLOW_DIV(SLOW_DIV)) u_pre_main (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel_i  (mode_q.clk_sel),
    .tick_o (tick_main)
  );

  generate
    if (HAS_CLK2) begin : g_clk2
      logic [2:0] sel2_q, sel2_d;
      always_comb sel2_d = (wr_en && wr_addr == ADDR_CLK2) ? wr_data[6:4] : sel2_q;
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) sel2_q <= '0;
        else             sel2_q <= sel2_d;
      end
      fanpwm_prescale #(.SLOW_DIV(SLOW_DIV)) u_pre_f2 (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .sel_i  (sel2_q),
        .tick_o (tick_alt)
      );
    end else begin : g_shared_clk
      assign tick_alt = tick_main;
    end
  endgenerate

  for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
    fanpwm_chan #(.DUTY_BITS(DUTY_BITS)) u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .tick_i     ((f == 1) ? tick_alt : tick_main),
      .smart_i    (smart_q[f]),
      .force_i    (mode_q.force_on[f]),
      .act_high_i (mode_q.act_high),
      .min_en_i   (mode_q.min_en),
      .ext_sel_i  (xsel_q[f]),
      .reg_duty_i (duty_q[f]),
      .ext_duty_i (ext_duty[8*f +: 8]),
      .pwm_o      (pwm_out[f])
    );
  end

endmodule

// File: tb/test_fan_pwm_gen.sv
module test_fan_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, w8_en;
  logic [3:0]  wr_addr, w8_addr;
  logic [7:0]  wr_data, w8_data;
  logic [23:0] ext_duty;
  logic [7:0]  ext8;
  logic [2:0]  pwm_out;
  logic [0:0]  pwm8;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fan_pwm_gen #(.NUM_FANS(3), .DUTY_BITS(7), .SLOW_DIV(20), .SEP_CLK2(1'b1)) i_fan_pwm_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_duty(ext_duty), .pwm_out(pwm_out));

  fan_pwm_gen #(.NUM_FANS(1), .DUTY_BITS(8), .SLOW_DIV(20), .SEP_CLK2(1'b0)) i_fan_pwm_gen_w8 (
    .clk(clk), .rst_n(rst_n), .wr_en(w8_en), .wr_addr(w8_addr), .wr_data(w8_data),
    .ext_duty(ext8), .pwm_out(pwm8));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); w8_en = 1'b1; w8_addr = a; w8_data = d;
    @(negedge clk); w8_en = 1'b0;
  endtask

  task automatic count_high(input int f, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (f < 0) c += int'(pwm8[0]); else c += int'(pwm_out[f]);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_len(input int f, output int len);
    int guard = 0;
    logic prev, cur;
    prev = pwm_out[f];
    len = 0;
    while (guard < 20000) begin
      @(negedge clk); guard++;
      cur = pwm_out[f];
      if (!prev && cur) break;
      prev = cur;
    end
    len = 1;
    while (guard < 40000) begin
      @(negedge clk); guard++;
      if (pwm_out[f]) len++; else break;
    end
  endtask

  task automatic t_reset;
    check("R1 reset outputs", int'(pwm_out), 7);
    check("R1 reset output w8", int'(pwm8[0]), 1);
  endtask

  task automatic t_duty;
    int c;
    wr(4'h0, 8'h80); wr(4'h1, 8'h01); wr(4'h4, 8'd100);
    settle(300); count_high(0, 128, c); check("R3 duty 100", c, 100);
    wr(4'h4, 8'd127); settle(300); count_high(0, 128, c); check("R3 full scale constant", c, 128);
    wr(4'h4, 8'd0);   settle(300); count_high(0, 128, c); check("R3 zero constant", c, 0);
    wr(4'h4, 8'd200); settle(300); count_high(0, 128, c); check("R3 saturate above full", c, 128);
  endtask

  task automatic t_polarity;
    int c;
    wr(4'h0, 8'h00); wr(4'h4, 8'd100);
    settle(300); count_high(0, 128, c); check("R4 active low", c, 28);
  endtask

  task automatic t_clksel;
    int len;
    wr(4'h0, 8'h90); settle(800);  run_len(0, len); check("R2 select 1 run", len, 200);
    wr(4'h0, 8'hB0); settle(2400); run_len(0, len); check("R2 select 3 run", len, 600);
    wr(4'h0, 8'hF0); settle(8000); run_len(0, len); check("R2 select 7 run", len, 2000);
  endtask

  task automatic t_force;
    int c;
    wr(4'h1, 8'h00); wr(4'h0, 8'h82); settle(4);
    count_high(0, 200, c); check("R5 forced off active high", c, 0);
    count_high(1, 200, c); check("R5 forced on active high", c, 200);
    wr(4'h0, 8'h02); settle(4);
    count_high(0, 200, c); check("R5 forced off active low", c, 200);
    count_high(1, 200, c); check("R5 forced on active low", c, 0);
  endtask

  task automatic t_min;
    int c;
    wr(4'h1, 8'h01); wr(4'h0, 8'h88);
    wr(4'h4, 8'd3);  settle(300); count_high(0, 128, c); check("R6 floor raises 3", c, 25);
    wr(4'h4, 8'd0);  settle(300); count_high(0, 128, c); check("R6 floor raises 0", c, 25);
    wr(4'h4, 8'd60); settle(300); count_high(0, 128, c); check("R6 above floor kept", c, 60);
  endtask

  task automatic t_ext;
    int c;
    wr(4'h0, 8'h80); wr(4'h4, 8'd100); ext_duty[7:0] = 8'd40; wr(4'h1, 8'h11);
    settle(300); count_high(0, 128, c); check("R8 external duty", c, 40);
    wr(4'h1, 8'h01);
  endtask

  task automatic t_boundary;
    int run = 1;
    logic prev, cur;
    wr(4'h0, 8'h80); wr(4'h4, 8'd100); settle(300);
    prev = pwm_out[0];
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); cur = pwm_out[0];
      if (!prev && cur) break;
      prev = cur;
    end
    repeat (10) begin @(negedge clk); run += int'(pwm_out[0]); end
    wr_en = 1'b1; wr_addr = 4'h4; wr_data = 8'd5;
    @(negedge clk); wr_en = 1'b0; run += int'(pwm_out[0]);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_out[0]) run++; else break;
    end
    check("R7 current period keeps old duty", run, 100);
    run_len(0, run); check("R7 next period uses new duty", run, 5);
  endtask

  task automatic t_clk2;
    int len;
    wr(4'h0, 8'h80); wr(4'h1, 8'h03); wr(4'h4, 8'd50); wr(4'h5, 8'd50); wr(4'h2, 8'h30);
    settle(2400);
    run_len(0, len); check("R9 fan1 shared select", len, 50);
    run_len(1, len); check("R9 fan2 own select", len, 300);
  endtask

  task automatic t_unmapped;
    int c;
    wr(4'h1, 8'h01); wr(4'h4, 8'd100); settle(300);
    wr(4'h3, 8'hFF); wr(4'hF, 8'hFF); settle(300);
    count_high(0, 128, c); check("R11 unmapped write ignored", c, 100);
  endtask

  task automatic t_wide;
    int c;
    wr8(4'h0, 8'h80); wr8(4'h1, 8'h01); wr8(4'h4, 8'd200);
    settle(600); count_high(-1, 256, c); check("R10 8-bit duty 200", c, 200);
    wr8(4'h4, 8'd255); settle(600); count_high(-1, 256, c); check("R10 8-bit full scale", c, 256);
    wr8(4'h0, 8'h88); wr8(4'h4, 8'd10); settle(600); count_high(-1, 256, c); check("R6 8-bit floor", c, 51);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    report();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    w8_en = 1'b0; w8_addr = '0; w8_data = '0; ext_duty = '0; ext8 = '0;
    settle(5); rst_n = 1'b1; settle(4);
    t_reset();
    t_duty();
    t_polarity();
    t_clksel();
    t_force();
    t_min();
    t_ext();
    t_boundary();
    t_clk2();
    t_unmapped();
    t_wide();
    report();
  end
endmodule